// File: doc/BRIEF.md
# Dual-Select Byte-Lane RAM Model

This block is a clocked, synthesizable behavioural model of a 16-bit static-style RAM. It has two chip selects of opposite polarity and a separate active-low enable for each byte lane. On every clock edge it samples the control inputs and classifies them into one of four modes: standby, output-off, read or write. It then stores the enabled byte lanes of the write data, or returns the enabled byte lanes of the addressed word.

A three-state data bus is represented by three separate buses. The write data arrives on an input bus. The read data leaves on an output bus. A two-bit drive flag marks each byte lane that would be actively driven. A lane whose drive flag is clear reads as zero on the output bus.

The storage depth is a parameter. The address is cut down to the bits the depth needs. Analog timing, access delays and power behaviour are not modelled.

Top module: `lane_ram`

## Requirements
- R1: After a synchronous active-low reset, `rdata_oe` is 2'b00 and `rdata` is zero.
- R2: When `sel_n` is high or `sel` is low, the part is in standby. The following cycle drives no lane, and the stored contents are not changed, whatever the other inputs are.
- R3: When `lo_en_n` and `hi_en_n` are both high, the part is deselected even with both selects active. No lane is driven in the following cycle and nothing is stored.
- R4: With the part selected, `we_n` high and `oe_n` high, no lane is driven in the following cycle.
- R5: With the part selected, `we_n` high and `oe_n` low, the cycle after drives the stored data only on the enabled lanes. `rdata_oe[0]` and `rdata[7:0]` follow `lo_en_n`. `rdata_oe[1]` and `rdata[15:8]` follow `hi_en_n`.
- R6: With the part selected and `we_n` low, only the lanes whose enable is low are written at the addressed word. The value of `oe_n` has no effect on this.
- R7: In the cycle after a write, no lane is driven.
- R8: A lane whose drive flag is clear shows zero on its `rdata` bits.
- R9: Only the low log2(DEPTH) address bits select a word. Addresses A and A+DEPTH reach the same word.
- R10: A read in the cycle right after a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| oe_n | input | 1 | Read output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lo_en_n | input | 1 | Lower byte lane enable (bits 7:0), active low |
| hi_en_n | input | 1 | Upper byte lane enable (bits 15:8), active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on lanes that are not driven |
| rdata_oe | output | 2 | Per-lane drive flag, bit 0 lower lane, bit 1 upper lane |

## Verification
Two functions meet at the same clock edge when a read and a write hit the same word back to back.

The edge that stores a write must also drop the drive left by the read before it. The edge that captures a read must see the word that the previous edge stored. The bench provokes both orders on a single address with no idle cycle between the operations. It judges the drive flags and the data one clock after each operation against a word value it tracks itself.

// File: rtl/lane_ram_pkg.sv
// Shared types for the byte-lane RAM model.
// Assumes: two byte lanes per word.
package lane_ram_pkg;

    // Operating mode resolved from the control inputs
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OUTOFF  = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } ram_mode_e;

endpackage

// File: rtl/lane_ram_decode.sv
// Mode decoder: turns the select, enable and lane inputs into per-lane
// read and write strobes.
// Assumes: the inputs are already synchronous to the sampling clock.
// The write mode has priority over the read enable.
module lane_ram_decode
    import lane_ram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_n,
    input  logic             sel,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic [LANES-1:0] rd_lanes,
    output logic [LANES-1:0] wr_lanes
);

    ram_mode_e        mode;
    logic             chip_on;
    logic [LANES-1:0] lane_on;

    // Chip is active only with both selects asserted and at least one lane on
    always_comb begin
        lane_on = ~lane_en_n;
        chip_on = !sel_n && sel && (lane_on != '0);
    end

    // Resolve the operating mode; write wins over output enable
    always_comb begin
        if (!chip_on)   mode = MODE_STANDBY;
        else if (!we_n) mode = MODE_WRITE;
        else if (!oe_n) mode = MODE_READ;
        else            mode = MODE_OUTOFF;
    end

    // Fan the mode out into per-lane strobes
    always_comb begin
        rd_lanes = (mode == MODE_READ)  ? lane_on : '0;
        wr_lanes = (mode == MODE_WRITE) ? lane_on : '0;
    end

endmodule

// File: rtl/lane_ram_bank.sv
// Storage for one byte lane, with a registered read port and a drive flag.
// Assumes: the storage array has no reset, so words never written are
// undefined. The read register and the drive flag reset to zero.
module lane_ram_bank #(
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata,
    output logic              drive
);

    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic              drive_q;

    // Store the lane byte on a write strobe
    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wdata;
    end

    // Capture read data and the drive flag one clock after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            drive_q <= 1'b0;
        end else begin
            drive_q <= rd_en;
            if (rd_en) rd_q <= mem[idx];
        end
    end

    // An undriven lane presents zero
    always_comb begin
        drive = drive_q;
        rdata = drive_q ? rd_q : '0;
    end

endmodule

// File: rtl/lane_ram.sv
// Top of the dual-select byte-lane RAM model. Decodes the controls once
// and hands per-lane strobes to one storage bank per byte lane.
// Assumes: DEPTH is at most 2**ADDR_W. Upper address bits are ignored.
module lane_ram #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                sel,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic                lo_en_n,
    input  logic                hi_en_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*LANE_W-1:0] wdata,
    output logic [2*LANE_W-1:0] rdata,
    output logic [1:0]          rdata_oe
);

    localparam int LANES = 2;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LANES-1:0] rd_lanes;
    logic [LANES-1:0] wr_lanes;
    logic [IDX_W-1:0] idx;

    // Cut the address down to the word index
    always_comb idx = addr[IDX_W-1:0];

    generate
        if (ADDR_W > IDX_W) begin : g_addr_tail
            logic addr_tail_unused;
            // Fold the ignored address bits so they are consumed
            always_comb addr_tail_unused = ^addr[ADDR_W-1:IDX_W];
        end
    endgenerate

    lane_ram_decode #(.LANES(LANES)) u_decode (
        .sel_n     (sel_n),
        .sel       (sel),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .lane_en_n ({hi_en_n, lo_en_n}),
        .rd_lanes  (rd_lanes),
        .wr_lanes  (wr_lanes)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            lane_ram_bank #(
                .DEPTH (DEPTH),
                .IDX_W (IDX_W),
                .LANE_W(LANE_W)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .idx   (idx),
                .wr_en (wr_lanes[g]),
                .rd_en (rd_lanes[g]),
                .wdata (wdata[g*LANE_W +: LANE_W]),
                .rdata (rdata[g*LANE_W +: LANE_W]),
                .drive (rdata_oe[g])
            );
        end
    endgenerate

endmodule

// File: rtl/lane_ram_chk.sv
// Checker for lane_ram: relates the sampled controls to the lane drive
// flags and data one clock later. Attached by bind below.
module lane_ram_chk #(
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel_n,
    input logic                sel,
    input logic                oe_n,
    input logic                we_n,
    input logic                lo_en_n,
    input logic                hi_en_n,
    input logic [2*LANE_W-1:0] rdata,
    input logic [1:0]          rdata_oe
);

    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel) |=> (rdata_oe == 2'b00));

    // R3
    lanes_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en_n && hi_en_n) |=> (rdata_oe == 2'b00));

    // R4
    outoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel && we_n && oe_n) |=> (rdata_oe == 2'b00));

    // R5
    read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel && we_n && !oe_n) |=> (rdata_oe == ~$past({hi_en_n, lo_en_n})));

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel && !we_n) |=> (rdata_oe == 2'b00));

    // R8
    lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe[0] |-> (rdata[LANE_W-1:0] == '0));

    // R8
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe[1] |-> (rdata[2*LANE_W-1:LANE_W] == '0));

endmodule

bind lane_ram lane_ram_chk #(.LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sel      (sel),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .lo_en_n  (lo_en_n),
    .hi_en_n  (hi_en_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/lane_ram_tb_top.sv
// Directed bench for lane_ram: one task per scenario, each checking itself.
module lane_ram_tb_top;

    localparam int DEPTH  = 1024;
    localparam int ADDR_W = 20;

    logic              clk     = 1'b0;
    logic              rst_n   = 1'b0;
    logic              sel_n   = 1'b1;
    logic              sel     = 1'b0;
    logic              oe_n    = 1'b1;
    logic              we_n    = 1'b1;
    logic              lo_en_n = 1'b1;
    logic              hi_en_n = 1'b1;
    logic [ADDR_W-1:0] addr    = '0;
    logic [15:0]       wdata   = '0;
    logic [15:0]       rdata;
    logic [1:0]        rdata_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    lane_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .oe_n(oe_n),
        .we_n(we_n), .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of controls at the falling edge, then settle after the rising edge
    task automatic cyc(input logic s_n, input logic s, input logic o_n, input logic w_n,
                       input logic l_n, input logic u_n, input logic [ADDR_W-1:0] a,
                       input logic [15:0] d);
        @(negedge clk);
        sel_n = s_n; sel = s; oe_n = o_n; we_n = w_n;
        lo_en_n = l_n; hi_en_n = u_n; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    // Selected read with the given lane enables; check drive flags and data
    task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic l_n,
                          input logic u_n, input logic [15:0] exp_d);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, l_n, u_n, a, 16'h0);
        chk({tag, " oe"}, {30'd0, rdata_oe}, {30'd0, ~u_n, ~l_n});
        chk({tag, " data"}, {16'd0, rdata}, {16'd0, exp_d});
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 oe", {30'd0, rdata_oe}, 32'd0);
        chk("R1 data", {16'd0, rdata}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R6 R7 R5: word write with oe_n low, then byte-lane writes and reads
    task automatic t_lanes();
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'd5, 16'h1234);
        chk("R7 oe after write", {30'd0, rdata_oe}, 32'd0);
        rd_chk("R5 word read", 20'd5, 1'b0, 1'b0, 16'h1234);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 20'd5, 16'hABCD);
        rd_chk("R6 lower write", 20'd5, 1'b0, 1'b0, 16'h12CD);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 20'd5, 16'h77EE);
        rd_chk("R6 upper write", 20'd5, 1'b0, 1'b0, 16'h77CD);
        rd_chk("R5 R8 lower read", 20'd5, 1'b0, 1'b1, 16'h00CD);
        rd_chk("R5 R8 upper read", 20'd5, 1'b1, 1'b0, 16'h7700);
    endtask

    // R2: standby from either select blocks writes and reads
    task automatic t_standby();
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'd5, 16'hFFFF);
        chk("R2 sel_n high oe", {30'd0, rdata_oe}, 32'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'd5, 16'hFFFF);
        chk("R2 sel low write oe", {30'd0, rdata_oe}, 32'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'd5, 16'h0);
        chk("R2 sel low read oe", {30'd0, rdata_oe}, 32'd0);
        chk("R2 R8 sel low read data", {16'd0, rdata}, 32'd0);
        rd_chk("R2 contents kept", 20'd5, 1'b0, 1'b0, 16'h77CD);
    endtask

    // R3: both lane enables high deselect the part
    task automatic t_lanes_off();
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 20'd5, 16'h0000);
        chk("R3 write oe", {30'd0, rdata_oe}, 32'd0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 20'd5, 16'h0000);
        chk("R3 read oe", {30'd0, rdata_oe}, 32'd0);
        rd_chk("R3 contents kept", 20'd5, 1'b0, 1'b0, 16'h77CD);
    endtask

    // R4: selected with both enables high drops the drive after a read
    task automatic t_outoff();
        rd_chk("R4 prior read", 20'd5, 1'b0, 1'b0, 16'h77CD);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'd5, 16'h0);
        chk("R4 oe", {30'd0, rdata_oe}, 32'd0);
        chk("R4 R8 data", {16'd0, rdata}, 32'd0);
    endtask

    // R9: address bits above the index are ignored
    task automatic t_alias();
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'(5 + DEPTH), 16'h5A5A);
        rd_chk("R9 alias low", 20'd5, 1'b0, 1'b0, 16'h5A5A);
        rd_chk("R9 alias high", 20'(5 + 3 * DEPTH), 1'b0, 1'b0, 16'h5A5A);
    endtask

    // R10 R7: back-to-back write and read on one word
    task automatic t_b2b();
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'd9, 16'h0F0F);
        rd_chk("R10 read after write", 20'd9, 1'b0, 1'b0, 16'h0F0F);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'd9, 16'hF0F0);
        chk("R7 write after read oe", {30'd0, rdata_oe}, 32'd0);
        chk("R7 R8 write after read data", {16'd0, rdata}, 32'd0);
        rd_chk("R10 second read", 20'd9, 1'b0, 1'b0, 16'hF0F0);
        rd_chk("R9 neighbour intact", 20'd5, 1'b0, 1'b0, 16'h5A5A);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lanes();
        t_standby();
        t_lanes_off();
        t_outoff();
        t_alias();
        t_b2b();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule